// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side once a program or erase command has gone to a flash device. It reads the device's status byte over and over through a simple read handshake. Each read is a cycle in which the request and the acknowledge are both high. The block decides whether the operation passed, failed, left the sector suspended, or ran out of attempts. The caller picks one of three polling styles at start: watching a toggling status bit, comparing a data bit against the value it expects, or detecting the suspend state.

The status a device returns can change from status to array data between two reads. For this reason an error flag never leads straight to a failure. It always triggers one more confirming read, or read pair, and only a result that still disagrees after that is reported as a failure. A programmable limit on undecided poll iterations produces a separate timeout result. Each outcome appears as a one-cycle done pulse together with a two-bit result code.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start pulse is accepted only while the block is idle. It latches the mode, the expected bit and the iteration limit. A start pulse that arrives while busy has no effect on the running poll or on its outcome.
- R2: While busy, rd_req stays high. Each cycle in which rd_req and rd_ack are both high consumes exactly one status byte. While rd_ack stays low, no read is consumed and no result is produced.
- R3: Toggle mode reads two bytes. If bit 6 is equal in both bytes, the result is pass after those two reads.
- R4: In toggle mode, if bit 6 differs and bit 5 of the second byte is 1, a confirming pair of two more reads follows. The result is pass if bit 6 is equal in that pair, and fail if it differs.
- R5: In toggle or suspend mode, if bit 6 differs and bit 5 of the second byte is 0, the iteration is undecided and a new pair is read.
- R6: Data mode reads one byte and compares its bit 7 with the expected bit (1 for erase). A match gives pass. On a mismatch with bit 5 = 1, one more byte is read: pass if bit 7 now matches, fail if not. On a mismatch with bit 5 = 0, the iteration is undecided.
- R7: Suspend mode reads a pair. If bit 6 is stable and bit 2 toggled, the result is suspended. If both bits are stable, the result is pass. If bit 6 toggled with bit 5 set, a confirming pair decides: bit 6 toggling means fail, bit 2 toggling alone means suspended, and no toggling means pass.
- R8: When the number of undecided iterations reaches the limit, the result is timeout. A limit of 0 behaves as 1.
- R9: done is high for exactly one cycle, in the cycle after the edge that consumed the final read. At the same time result takes its code (0 pass, 1 fail, 2 suspended, 3 timeout) and holds it until the next done. busy is low while done is high.
- R10: The mode codes are 0 toggle, 1 data and 2 suspend. Code 3 behaves as toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling |
| mode | input | 2 | Polling style, latched at start |
| exp_bit | input | 1 | Expected bit 7 for data mode |
| poll_limit | input | CNT_W | Maximum undecided iterations |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read data valid; consumes one byte |
| rd_data | input | 8 | Status byte from the device |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Outcome code |

## Verification
The bench feeds byte sequences in which the error flag appears with a toggling bit. This separates a design that confirms the error from one that reports failure at once, which would turn a harmless status-to-data transition into a false fail. Every result is checked against the number of reads consumed, so a design that skips or adds a confirming read is caught even when it reaches the right code. A timeout limit of 2 and a limit of 0 expose off-by-one errors in the iteration counter. A second start issued in the middle of a poll, and an acknowledge held low, show whether a design wrongly restarts or runs ahead without data.

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             exp_bit,
  input  logic [CNT_W-1:0] poll_limit,
  output logic             rd_req,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  localparam logic [1:0] MODE_DATA = 2'd1;
  localparam logic [1:0] MODE_SUSP = 2'd2;
  localparam logic [1:0] RES_PASS  = 2'd0;
  localparam logic [1:0] RES_FAIL  = 2'd1;
  localparam logic [1:0] RES_SUSP  = 2'd2;
  localparam logic [1:0] RES_TOUT  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_CF1, S_CF2} st_t;

  st_t             st, nxt;
  logic [1:0]      md;
  logic            exp_q;
  logic [CNT_W-1:0] lim_q, iter;
  logic [7:0]      prev;
  logic            fin, miss;
  logic [1:0]      code;

  wire t6       = prev[6] ^ rd_data[6];
  wire t2       = prev[2] ^ rd_data[2];
  wire d7ok     = rd_data[7] == exp_q;
  wire is_data  = md == MODE_DATA;
  wire is_susp  = md == MODE_SUSP;
  wire last_it  = ({1'b0, iter} + (CNT_W+1)'(1)) >= {1'b0, lim_q};
  wire [1:0] stable_res = (is_susp && t2) ? RES_SUSP : RES_PASS;

  assign busy   = st != S_IDLE;
  assign rd_req = busy;

  always_comb begin
    nxt  = st;
    fin  = 1'b0;
    miss = 1'b0;
    code = RES_PASS;
    case (st)
      S_IDLE: if (start) nxt = S_RD1;
      S_RD1: if (rd_ack) begin
        if (!is_data)        nxt = S_RD2;
        else if (d7ok)       fin = 1'b1;
        else if (rd_data[5]) nxt = S_CF2;
        else                 miss = 1'b1;
      end
      S_RD2: if (rd_ack) begin
        if (!t6) begin
          fin  = 1'b1;
          code = stable_res;
        end else if (rd_data[5]) nxt = S_CF1;
        else                     miss = 1'b1;
      end
      S_CF1: if (rd_ack) nxt = S_CF2;
      S_CF2: if (rd_ack) begin
        fin = 1'b1;
        if (is_data) code = d7ok ? RES_PASS : RES_FAIL;
        else         code = t6 ? RES_FAIL : stable_res;
      end
      default: nxt = S_IDLE;
    endcase
    if (miss) begin
      if (last_it) begin
        fin  = 1'b1;
        code = RES_TOUT;
      end else nxt = S_RD1;
    end
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= '0;
      exp_q  <= 1'b0;
      lim_q  <= '0;
      iter   <= '0;
      prev   <= '0;
      done   <= 1'b0;
      result <= RES_PASS;
    end else begin
      st   <= nxt;
      done <= fin;
      if (fin) result <= code;
      if (st == S_IDLE && start) begin
        md    <= mode;
        exp_q <= exp_bit;
        lim_q <= poll_limit;
        iter  <= '0;
      end
      if (miss && !last_it) iter <= iter + CNT_W'(1);
      if (rd_ack && (st == S_RD1 || st == S_CF1)) prev <= rd_data;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result))); // R9
  AST_DATA_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_data) |-> result != RES_SUSP); // R6
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lim_q != '0) |-> iter < lim_q); // R8

endmodule

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, exp_bit = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [15:0] poll_limit = 16'd5;
  logic rd_req, rd_ack = 1'b0, busy, done;
  logic [7:0] rd_data = 8'h00;
  logic [1:0] result;

  int checks = 0, fails = 0, nreads = 0, ndone = 0, base = 0, cyc = 0;
  logic resp_en = 1'b1;
  logic [47:0] stream = '0;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.CNT_W(16)) i_flash_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .exp_bit(exp_bit),
    .poll_limit(poll_limit), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .result(result));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done) ndone = ndone + 1;
    if (resp_en && rd_req) begin
      rd_ack  = 1'b1;
      rd_data = ((nreads - base) < 6) ? stream[(nreads - base)*8 +: 8] : 8'h00;
      nreads  = nreads + 1;
    end else rd_ack = 1'b0;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    checks = checks + 1;
    if (act != expv) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic e, input logic [15:0] lim,
                     input logic [47:0] s, input int er, input int ereads, input string tag);
    int d0;
    int w;
    @(negedge clk);
    stream = s; mode = m; exp_bit = e; poll_limit = lim;
    base = nreads; d0 = ndone;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (ndone == d0 && w < 300) begin
      @(negedge clk);
      w = w + 1;
    end
    repeat (3) @(negedge clk);
    check({tag, " result"}, int'(result), er);
    check({tag, " reads"}, nreads - base, ereads);
    check("R9 single done", ndone - d0, 1);
  endtask

  localparam int NV = 15;
  localparam logic [58:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'd5, 48'h0000_0000_0000, 2'd0, 2'd2},  // R3 stable
    {2'd0, 1'b0, 4'd5, 48'h0000_4040_4000, 2'd0, 2'd0},  // R5 retry, 4 reads
    {2'd0, 1'b0, 4'd5, 48'h0000_6020_6000, 2'd1, 2'd0},  // R4 fail
    {2'd0, 1'b0, 4'd5, 48'h0000_6060_6000, 2'd0, 2'd0},  // R4 false alarm
    {2'd1, 1'b1, 4'd5, 48'h0000_0000_0080, 2'd0, 2'd1},  // R6 erase match
    {2'd1, 1'b1, 4'd5, 48'h0000_0000_0020, 2'd1, 2'd2},  // R6 fail
    {2'd1, 1'b1, 4'd5, 48'h0000_0000_8020, 2'd0, 2'd2},  // R6 late match
    {2'd1, 1'b0, 4'd5, 48'h0000_0000_8080, 2'd0, 2'd3},  // R6 retry
    {2'd2, 1'b0, 4'd5, 48'h0000_0000_0400, 2'd2, 2'd2},  // R7 suspended
    {2'd2, 1'b0, 4'd5, 48'h0000_0000_0404, 2'd0, 2'd2},  // R7 complete
    {2'd2, 1'b0, 4'd5, 48'h0000_4000_6400, 2'd1, 2'd0},  // R7 confirm fail
    {2'd2, 1'b0, 4'd5, 48'h0000_2420_6400, 2'd2, 2'd0},  // R7 confirm suspended
    {2'd0, 1'b0, 4'd2, 48'h0000_4000_4000, 2'd3, 2'd0},  // R8 limit 2
    {2'd0, 1'b0, 4'd0, 48'h0000_0000_4000, 2'd3, 2'd2},  // R8 limit 0
    {2'd3, 1'b0, 4'd5, 48'h0000_0000_0000, 2'd0, 2'd2}   // R10 mode 3
  };

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset done", int'(done), 0);
    check("R2 reset rd_req", int'(rd_req), 0);
    check("R9 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      int nr;
      v = VEC[i];
      nr = (v[1:0] == 2'd0) ? 4 : int'(v[1:0]);
      run(v[58:57], v[56], {12'd0, v[55:52]}, v[51:4], int'(v[3:2]), nr,
          v[58:57] == 2'd1 ? "R6" : v[58:57] == 2'd2 ? "R7" :
          v[3:2] == 2'd3 ? "R8" : "R3/R4/R5/R10");
    end
    begin
      int r0;
      int d0;
      resp_en = 1'b0;
      stream = 48'h0000_4040_4000; mode = 2'd0; poll_limit = 16'd5;
      base = nreads; r0 = nreads; d0 = ndone;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 req held", int'(rd_req), 1);
      check("R2 no reads", nreads - r0, 0);
      check("R2 no done", ndone - d0, 0);
      mode = 2'd1; exp_bit = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; mode = 2'd0;
      resp_en = 1'b1;
      repeat (20) @(negedge clk);
      check("R1 ignored start result", int'(result), 0);
      check("R1 ignored start reads", nreads - base, 4);
      check("R1 done count", ndone - d0, 1);
      check("R9 result held", int'(result), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule